// File: doc/BRIEF.md
# Dual-Clock FIFO with Per-Domain Fill Levels

This block moves data words from a write clock domain into an unrelated read clock domain. Each domain keeps its own binary position counter. The write domain owns the next-write counter and the read domain owns the next-read counter. Each counter is turned into a one-bit-per-step code and registered in its own domain. The far domain samples it through a chain of flip-flops of configurable length, then decodes it back to binary.

Each side subtracts the remote position it has received from its own position. The result is that side's view of how many words are held. Because the remote position always arrives late, the writer's view can only be too high and the reader's view can only be too low. So the writer can never overrun the storage, and the reader can never take a word that is not there. A longer synchronizer chain only delays these views. It never makes them wrong, whatever the ratio between the two clock frequencies.

The write side reports its count and a full flag. The read side reports its count, an empty flag, and registered read data with a valid strobe.

Top module: `dual_clock_fifo`

## Requirements
- R1: Every word written while `wr_full` is low is delivered on `rd_data` exactly once, in the order it was written.
- R2: Each position counter crosses domains as a registered code in which consecutive values differ in exactly one bit, so the value seen by the far side never jumps backwards.
- R3: `wr_level` equals the write position minus the read position as synchronized into the write domain, modulo twice DEPTH. It never exceeds DEPTH, and `wr_full` is high exactly when `wr_level` equals DEPTH.
- R4: A write attempted while `wr_full` is high is ignored. Exactly DEPTH of any burst into an empty FIFO are kept, and `wr_level` does not rise on that cycle.
- R5: `rd_level` equals the synchronized write position minus the read position. It never exceeds DEPTH, and `rd_empty` is high exactly when `rd_level` is zero.
- R6: A read accepted at a `rd_clk` edge (`rd_en` high, `rd_empty` low) drives `rd_valid` high with the word on `rd_data` after that edge. `rd_valid` returns low after the next edge if no read is accepted there.
- R7: A read attempted while `rd_empty` is high is ignored: `rd_valid` stays low and no word is consumed.
- R8: After both resets, `wr_level` and `rd_level` are 0, `rd_empty` is 1, and `wr_full` and `rd_valid` are 0.
- R9: Once the traffic stops, each level settles to the true occupancy within a few cycles of its own clock beyond the synchronizer depth.
- R10: R1 through R7 hold with the write clock about five times faster than the read clock, with the read clock faster than the write clock, and with more than the minimum of two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No room, writes ignored |
| wr_level | output | $clog2(DEPTH)+1 | Write-side conservative occupancy |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered read word |
| rd_valid | output | 1 | `rd_data` holds a freshly read word |
| rd_empty | output | 1 | Nothing to read, reads ignored |
| rd_level | output | $clog2(DEPTH)+1 | Read-side conservative occupancy |

## Verification
The bench pushes a burst longer than the storage into an empty FIFO. A design that compared pointers without the extra wrap bit would take too many or too few words, or would show full as empty. It keeps reading after the FIFO drains. A design that did not gate reads on the count would emit stale words with `rd_valid` high or move its read position past the writer. Streaming with a five-to-one fast writer, and then with a fast reader, checks order against a model queue. A crossing that used plain binary or subtracted with the wrong sign would lose, repeat or reorder words, and would push a level above DEPTH. Settling checks after idle periods catch a level that never catches up with the far side.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // Fewest flip-flops a crossing chain may have; shorter requests are raised to this.
  localparam int unsigned MIN_SYNC = 2;
endpackage

// File: rtl/dcf_ptr_cross.sv
module dcf_ptr_cross
  import dcf_pkg::*;
#(
  parameter int PW     = 5,
  parameter int STAGES = 2
) (
  input  logic          src_clk,
  input  logic          src_rst,
  input  logic [PW-1:0] src_bin,
  input  logic          dst_clk,
  input  logic          dst_rst,
  output logic [PW-1:0] dst_bin
);
  localparam int NSTG = (STAGES < int'(MIN_SYNC)) ? int'(MIN_SYNC) : STAGES;
  localparam int SPAN = 2 ** (PW - 1);

  // Source side: registered code, one bit changes per increment, no glitches leave.
  logic [PW-1:0] src_gray;
  always_ff @(posedge src_clk) begin
    if (src_rst) src_gray <= '0;
    else         src_gray <= src_bin ^ (src_bin >> 1);
  end

  // Destination side: flip-flop chain.
  logic [PW-1:0] chain [NSTG];
  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      for (int i = 0; i < NSTG; i++) chain[i] <= '0;
    end else begin
      chain[0] <= src_gray;
      for (int i = 1; i < NSTG; i++) chain[i] <= chain[i-1];
    end
  end

  // Decode: each binary bit is the XOR of all code bits at or above it.
  logic [PW-1:0] decoded;
  for (genvar b = 0; b < PW; b++) begin : g_dec
    assign decoded[b] = ^chain[NSTG-1][PW-1:b];
  end

  always_ff @(posedge dst_clk) begin
    if (dst_rst) dst_bin <= '0;
    else         dst_bin <= decoded;
  end

  // R2: the registered code moves by at most one bit per source cycle.
  a_r2_gray_one_step: assert property (@(posedge src_clk) disable iff (src_rst)
    $countones(src_gray ^ $past(src_gray)) <= 1);

  // R2: the received position only moves forward, never by more than the span.
  a_r2_remote_forward: assert property (@(posedge dst_clk) disable iff (dst_rst)
    (PW'(dst_bin - $past(dst_bin))) <= SPAN);
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 2 ** AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import dcf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     wr_clk,
  input  logic                     wr_rst,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     wr_full,
  output logic [$clog2(DEPTH):0]   wr_level,
  input  logic                     rd_clk,
  input  logic                     rd_rst,
  input  logic                     rd_en,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic                     rd_empty,
  output logic [$clog2(DEPTH):0]   rd_level
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW-1:0] rd_ptr_at_wr, wr_ptr_at_rd;
  logic          wr_go, rd_go;

  // Write domain
  assign wr_level = wr_ptr - rd_ptr_at_wr;
  assign wr_full  = (wr_level == PW'(DEPTH));
  assign wr_go    = wr_en && !wr_full;

  always_ff @(posedge wr_clk) begin
    if (wr_rst)     wr_ptr <= '0;
    else if (wr_go) wr_ptr <= wr_ptr + 1'b1;
  end

  // Read domain
  assign rd_level = wr_ptr_at_rd - rd_ptr;
  assign rd_empty = (rd_level == '0);
  assign rd_go    = rd_en && !rd_empty;

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rd_ptr   <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // Crossings
  dcf_ptr_cross #(.PW(PW), .STAGES(SYNC_STAGES)) u_wr_to_rd (
    .src_clk (wr_clk), .src_rst (wr_rst), .src_bin (wr_ptr),
    .dst_clk (rd_clk), .dst_rst (rd_rst), .dst_bin (wr_ptr_at_rd)
  );

  dcf_ptr_cross #(.PW(PW), .STAGES(SYNC_STAGES)) u_rd_to_wr (
    .src_clk (rd_clk), .src_rst (rd_rst), .src_bin (rd_ptr),
    .dst_clk (wr_clk), .dst_rst (wr_rst), .dst_bin (rd_ptr_at_wr)
  );

  // Storage
  dcf_store #(.DW(DATA_W), .AW(AW)) u_store (
    .wr_clk (wr_clk), .we (wr_go), .waddr (wr_ptr[AW-1:0]), .wdata (wr_data),
    .rd_clk (rd_clk), .re (rd_go), .raddr (rd_ptr[AW-1:0]), .rdata (rd_data)
  );

  // R3: the writer's view never claims more than the storage holds.
  a_r3_wr_level_cap: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_level <= DEPTH);

  // R4: a refused write cannot raise the writer's count.
  a_r4_full_write_no_rise: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_full && wr_en) |=> (wr_level <= $past(wr_level)));

  // R5: the reader's view stays inside the storage size.
  a_r5_rd_level_cap: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_level <= DEPTH);

  // R7: a read attempted on an empty FIFO produces no word.
  a_r7_empty_read_no_valid: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_en && rd_empty) |=> !rd_valid);
endmodule

// File: tb/dual_clock_fifo_bench.sv
`timescale 1ns/10ps
module dual_clock_fifo_bench;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int STG   = 3;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst = 1'b1, rd_rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_full, rd_valid, rd_empty;
  logic [LW-1:0] wr_level, rd_level;
  logic [DW-1:0] rd_data;

  realtime rd_half = 10.5;
  always #2 wr_clk = ~wr_clk;
  always #(rd_half) rd_clk = ~rd_clk;

  dual_clock_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(STG)) u_dual_clock_fifo (
    .wr_clk (wr_clk), .wr_rst (wr_rst), .wr_en (wr_en), .wr_data (wr_data),
    .wr_full (wr_full), .wr_level (wr_level),
    .rd_clk (rd_clk), .rd_rst (rd_rst), .rd_en (rd_en), .rd_data (rd_data),
    .rd_valid (rd_valid), .rd_empty (rd_empty), .rd_level (rd_level)
  );

  int n_chk = 0, n_bad = 0, n_rx = 0;
  logic [DW-1:0] model [$];
  logic [DW-1:0] exp_word;
  logic [DW-1:0] next_data = 8'h10;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Delivery monitor (R1, R6)
  always @(negedge rd_clk) begin
    if (!rd_rst && rd_valid) begin
      if (model.size() == 0) begin
        check(1'b0, "R1 word with nothing expected", int'(rd_data), -1);
      end else begin
        exp_word = model.pop_front();
        check(rd_data == exp_word, "R1 order", int'(rd_data), int'(exp_word));
      end
      n_rx++;
    end
  end

  // Level bounds (R3, R5)
  always @(negedge wr_clk) begin
    if (!wr_rst) begin
      check(wr_level <= DEPTH, "R3 wr_level bound", int'(wr_level), DEPTH);
      check(wr_full == (wr_level == DEPTH), "R3 full flag", int'(wr_full), int'(wr_level == DEPTH));
    end
  end
  always @(negedge rd_clk) begin
    if (!rd_rst) begin
      check(rd_level <= DEPTH, "R5 rd_level bound", int'(rd_level), DEPTH);
      check(rd_empty == (rd_level == 0), "R5 empty flag", int'(rd_empty), int'(rd_level == 0));
    end
  end

  task automatic wr_cycle(input bit en, input logic [DW-1:0] d, output bit acc);
    @(negedge wr_clk);
    wr_en   = en;
    wr_data = d;
    acc     = en && !wr_full;
    if (acc) model.push_back(d);
  endtask

  task automatic t_reset();
    wr_en = 1'b0; rd_en = 1'b0;
    wr_rst = 1'b1; rd_rst = 1'b1;
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
    model.delete();
    @(negedge wr_clk) wr_rst = 1'b0;
    @(negedge rd_clk) rd_rst = 1'b0;
    @(negedge wr_clk);
    check(wr_level == 0, "R8 wr_level", int'(wr_level), 0);
    check(wr_full == 1'b0, "R8 wr_full", int'(wr_full), 0);
    @(negedge rd_clk);
    check(rd_level == 0, "R8 rd_level", int'(rd_level), 0);
    check(rd_empty == 1'b1, "R8 rd_empty", int'(rd_empty), 1);
    check(rd_valid == 1'b0, "R8 rd_valid", int'(rd_valid), 0);
  endtask

  task automatic t_fill();
    int taken = 0;
    bit acc;
    for (int i = 0; i < DEPTH + 4; i++) begin
      wr_cycle(1'b1, 8'h40 + 8'(i), acc);
      if (acc) taken++;
    end
    @(negedge wr_clk) wr_en = 1'b0;
    check(taken == DEPTH, "R4 words kept from long burst", taken, DEPTH);
    check(wr_full == 1'b1, "R3 full after burst", int'(wr_full), 1);
    check(wr_level == DEPTH, "R3 wr_level after burst", int'(wr_level), DEPTH);
    repeat (STG + 4) @(negedge rd_clk);
    check(rd_level == DEPTH, "R9 rd_level settles to DEPTH", int'(rd_level), DEPTH);
    check(rd_empty == 1'b0, "R5 not empty when full", int'(rd_empty), 0);
  endtask

  task automatic t_drain();
    int target;
    target = n_rx + DEPTH;
    @(negedge rd_clk) rd_en = 1'b1;
    repeat (DEPTH + STG + 6) @(negedge rd_clk);
    check(n_rx == target, "R4 drained word count", n_rx, target);
    check(model.size() == 0, "R4 nothing left in model", model.size(), 0);
    check(rd_empty == 1'b1, "R5 empty after drain", int'(rd_empty), 1);
    // rd_en still high while empty
    @(negedge rd_clk);
    check(rd_valid == 1'b0, "R7 read on empty gives no word", int'(rd_valid), 0);
    check(rd_level == 0, "R7 rd_level stays zero", int'(rd_level), 0);
    rd_en = 1'b0;
    repeat (STG + 4) @(negedge wr_clk);
    check(wr_level == 0, "R9 wr_level settles to zero", int'(wr_level), 0);
    check(wr_full == 1'b0, "R9 not full after drain", int'(wr_full), 0);
  endtask

  task automatic t_latency();
    bit acc;
    int guard = 0;
    wr_cycle(1'b1, 8'hA5, acc);
    @(negedge wr_clk) wr_en = 1'b0;
    check(acc == 1'b1, "R1 single write taken", int'(acc), 1);
    @(negedge rd_clk);
    while (rd_empty && guard < 40) begin
      @(negedge rd_clk);
      guard++;
    end
    check(rd_empty == 1'b0, "R9 word becomes visible", int'(rd_empty), 0);
    rd_en = 1'b1;
    @(negedge rd_clk);
    check(rd_valid == 1'b1, "R6 valid one cycle after read", int'(rd_valid), 1);
    check(rd_data == 8'hA5, "R6 read data", int'(rd_data), 8'hA5);
    rd_en = 1'b0;
    @(negedge rd_clk);
    check(rd_valid == 1'b0, "R6 valid drops without read", int'(rd_valid), 0);
  endtask

  task automatic t_stream(input realtime half, input int n, input bit rd_dense, input string tag);
    int target;
    rd_half = half;
    target  = n_rx + n;
    fork
      begin : writer
        logic [15:0] ws = 16'hACE1;
        int sent = 0;
        bit acc;
        while (sent < n) begin
          ws = step(ws);
          wr_cycle(ws[0] | ws[3], next_data, acc);
          if (acc) begin
            sent++;
            next_data = next_data + 8'd7;
          end
        end
        @(negedge wr_clk) wr_en = 1'b0;
      end
      begin : reader
        logic [15:0] rs = 16'h5A3C;
        int guard = 0;
        while (n_rx < target && guard < 30000) begin
          @(negedge rd_clk);
          rs = step(rs);
          rd_en = rd_dense | rs[2];
          guard++;
        end
        rd_en = 1'b0;
      end
    join
    repeat (STG + 6) @(negedge rd_clk);
    check(n_rx == target, {"R10 words delivered, ", tag}, n_rx, target);
    check(model.size() == 0, {"R2 no word lost in crossing, ", tag}, model.size(), 0);
    check(rd_empty == 1'b1, {"R5 empty at end, ", tag}, int'(rd_empty), 1);
    repeat (STG + 6) @(negedge wr_clk);
    check(wr_level == 0, {"R9 wr_level idle, ", tag}, int'(wr_level), 0);
  endtask

  initial begin : watchdog
    #700us;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    t_reset();
    t_fill();
    t_drain();
    t_latency();
    t_stream(10.5, 300, 1'b1, "fast writer");
    t_reset();
    t_stream(1.65, 300, 1'b0, "fast reader");
    t_stream(10.5, 200, 1'b0, "fast writer, sparse reads");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule